// File: doc/BRIEF.md
# Indexed single-bit I/O pin bank

This block holds a bank of single-bit discrete pins for a small 4-bit controller. The core sends it one command at a time over a valid/ready stream. Each command carries an operation and a pin index. Two of the operations write the output latch of the addressed pin: one writes a 1 and the other writes a 0. A third operation reads the level on the addressed pin and returns it as a one-bit response on a second valid/ready stream. Every pad is open-drain. A latch holding 0 asserts that pad's pull-down enable. A latch holding 1 releases the pad. Each pin also has a static pull-up selection, which the block passes through to a separate pull-up enable output.

A halt input lets the rest of the chip put the bank to sleep. When the per-device parameter `HALT_FLOAT` is set, halt does three things. It releases every pull-down. It turns off every pull-up. It gates the input path so that a read returns 0. The latches keep their contents while halted and can still be written, and the pads show the latch contents again once halt drops. When `HALT_FLOAT` is clear, halt has no effect.

Back-pressure works as follows. `cmd_ready` is high whenever the single response slot is empty or is being emptied in the same cycle (`rsp_ready` high). A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no command is accepted, whatever its kind.

Top module: `pinbank_io`

## Requirements
- R1: After reset all latches hold 1. So `pad_oe` is all zero, `pad_pu` equals `cfg_pullup`, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: An accepted command with `cmd_op` = 2'b01 (set) and an in-range index writes 1 to that pin's latch. `pad_oe[idx]` reads 0 from the first sample after the accepting edge.
- R3: An accepted command with `cmd_op` = 2'b10 (clear) and an in-range index writes 0 to that pin's latch. `pad_oe[idx]` reads 1 from the first sample after the accepting edge, unless the pads are floated.
- R4: A set or clear changes only the addressed latch. Every latch keeps its value until a set or clear addresses it.
- R5: An accepted command with `cmd_op` = 2'b11 (test) raises `rsp_valid` after the accepting edge. `rsp_level` equals `pad_in[idx]`, provided that input was stable for at least `SYNC_STAGES` edges before acceptance.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `cmd_ready` is 0, the response is held unchanged, and a presented command has no effect. `rsp_valid` drops on the edge where `rsp_ready` is 1 and no new test is accepted.
- R7: When the pads are not floated, `pad_pu[i]` equals `cfg_pullup[i]` for every pin.
- R8: With `HALT_FLOAT` set and `halt` high, `pad_oe` and `pad_pu` are all zero and a test returns 0. Set and clear still update the latches, and the updated contents reappear on `pad_oe` once `halt` falls.
- R9: With `HALT_FLOAT` clear, `halt` changes neither the pad outputs nor the tested levels.
- R10: A command whose index is NPINS or higher is accepted but changes no latch. A test with such an index returns `rsp_level` 0.
- R11: `cmd_op` = 2'b00 is a no-op. It is accepted, changes no latch and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 00 no-op, 01 set, 10 clear, 11 test |
| cmd_idx | input | IDX_W | Pin index |
| rsp_valid | output | 1 | Test result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_level | output | 1 | Sampled pin level |
| halt | input | 1 | Device halted |
| cfg_pullup | input | NPINS | Static per-pin pull-up selection |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_oe | output | NPINS | Open-drain pull-down enable per pin |
| pad_pu | output | NPINS | Pull-up enable per pin |

## Verification
The timing the checks rely on is as follows:
- A set or clear changes `pad_oe` with no delay beyond the latch itself, so the first falling-edge sample after the accepting rising edge already shows the new level.
- A test's response shows up at that same sample.
- A change on `pad_in` needs `SYNC_STAGES` rising edges before a test can see it.
- A change on `halt` reaches the pads combinationally.

The bench therefore changes inputs on a falling edge. It holds each command for exactly one rising edge and checks at the falling edge that follows. After moving `pad_in` it waits three cycles before issuing a test. Held-response behaviour is checked over several cycles with `rsp_ready` low.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_TEST = 2'b11
  } pin_op_e;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int IDX_W = 4
) (
  input  logic             fire,
  input  pin_op_e          op,
  input  logic [IDX_W-1:0] idx,
  output logic [NPINS-1:0] hit,
  output logic             in_range,
  output logic [NPINS-1:0] set_mask,
  output logic [NPINS-1:0] clr_mask
);
  // Only populated pins get a comparator, so indices past NPINS match nothing.
  for (genvar i = 0; i < NPINS; i++) begin : g_hit
    assign hit[i]      = (idx == IDX_W'(i));
    assign set_mask[i] = fire && (op == OP_SET) && hit[i];
    assign clr_mask[i] = fire && (op == OP_CLR) && hit[i];
  end

  assign in_range = |hit;
endmodule

// File: rtl/pinbank_latches.sv
module pinbank_latches #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_mask,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] q
);
  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q[i] <= 1'b1;
      else if (set_mask[i]) q[i] <= 1'b1;
      else if (clr_mask[i]) q[i] <= 1'b0;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> q[i]);                                          // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[i] |=> !q[i]);                                         // R3
    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_mask[i] || clr_mask[i]) |=> $stable(q[i]));               // R4
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_mask | clr_mask));                                   // R4
endmodule

// File: rtl/pinbank_sampler.sv
module pinbank_sampler #(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] hit,
  input  logic             in_enable,
  output logic             level
);
  logic [NPINS-1:0] stage [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= pad_in;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  // Gate the input path first, then pick the addressed pin.
  logic [NPINS-1:0] gated;
  assign gated = in_enable ? stage[SYNC_STAGES-1] : '0;
  assign level = |(gated & hit);
endmodule

// File: rtl/pinbank_resp.sv
module pinbank_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic level_in,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_level,
  output logic slot_free
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_level <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_level <= level_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_level)));  // R6
  AST_RSP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !take) |=> !rsp_valid);                 // R6
endmodule

// File: rtl/pinbank_io.sv
module pinbank_io
  import pinbank_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit HALT_FLOAT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_level,
  input  logic             halt,
  input  logic [NPINS-1:0] cfg_pullup,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu
);
  pin_op_e          op;
  logic             fire;
  logic             slot_free;
  logic             floated;
  logic             in_range;
  logic             level;
  logic [NPINS-1:0] hit, set_mask, clr_mask, latch_q;

  assign op        = pin_op_e'(cmd_op);
  assign cmd_ready = slot_free;
  assign fire      = cmd_valid && slot_free;

  if (HALT_FLOAT) begin : g_float
    assign floated = halt;
  end else begin : g_keep
    assign floated = 1'b0;
  end

  pinbank_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_decode (
    .fire(fire), .op(op), .idx(cmd_idx), .hit(hit), .in_range(in_range),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  pinbank_latches #(.NPINS(NPINS)) u_latches (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .q(latch_q)
  );

  pinbank_sampler #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .hit(hit),
    .in_enable(!floated), .level(level)
  );

  pinbank_resp u_resp (
    .clk(clk), .rst_n(rst_n), .take(fire && (op == OP_TEST)),
    .level_in(level), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_level(rsp_level), .slot_free(slot_free)
  );

  // Open-drain pad: a latch at 0 pulls low. Floating releases pull-down and pull-up.
  assign pad_oe = floated ? '0 : ~latch_q;
  assign pad_pu = floated ? '0 : cfg_pullup;

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_range) |=> $stable(latch_q));                        // R10
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_NOP) |=> ($stable(latch_q) && !rsp_valid));     // R11
  AST_HALT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_TEST && floated) |=> (rsp_valid && !rsp_level)); // R8
  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(latch_q));                  // R6
endmodule

// File: tb/pinbank_io_bench.sv
module pinbank_io_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Main instance: 16 pins, halt floats the pads
  logic        cmd_valid = 0, rsp_ready = 1, halt = 0;
  logic [1:0]  cmd_op = 0;
  logic [3:0]  cmd_idx = 0;
  logic        cmd_ready, rsp_valid, rsp_level;
  logic [15:0] cfg_pullup = 16'hA5C3, pad_in = 16'h0000, pad_oe, pad_pu;

  pinbank_io u_pinbank_io (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_level(rsp_level), .halt(halt),
    .cfg_pullup(cfg_pullup), .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // Narrow instance: 12 pins, halt leaves the pads alone
  logic        n_cmd_valid = 0, n_halt = 0;
  logic [1:0]  n_cmd_op = 0;
  logic [3:0]  n_cmd_idx = 0;
  logic        n_cmd_ready, n_rsp_valid, n_rsp_level;
  logic [11:0] n_cfg = 12'h5A3, n_pad_in = 12'h000, n_pad_oe, n_pad_pu;

  pinbank_io #(.NPINS(12), .IDX_W(4), .SYNC_STAGES(2), .HALT_FLOAT(1'b0))
  u_pinbank_io_narrow (
    .clk(clk), .rst_n(rst_n), .cmd_valid(n_cmd_valid), .cmd_ready(n_cmd_ready),
    .cmd_op(n_cmd_op), .cmd_idx(n_cmd_idx), .rsp_valid(n_rsp_valid),
    .rsp_ready(1'b1), .rsp_level(n_rsp_level), .halt(n_halt),
    .cfg_pullup(n_cfg), .pad_in(n_pad_in), .pad_oe(n_pad_oe), .pad_pu(n_pad_pu)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [3:0] idx);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = idx;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send_n(logic [1:0] op, logic [3:0] idx);
    @(negedge clk);
    n_cmd_valid = 1; n_cmd_op = op; n_cmd_idx = idx;
    @(negedge clk);
    n_cmd_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_pu", 32'(pad_pu), 32'hA5C3);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'h1);
  endtask

  task automatic t_write;
    send(2'b10, 4'd3);
    check("R3 clear pin3", 32'(pad_oe), 32'h0008);
    send(2'b10, 4'd15);
    check("R3 clear pin15", 32'(pad_oe), 32'h8008);
    check("R4 pin3 kept", 32'(pad_oe[3]), 32'h1);
    send(2'b01, 4'd3);
    check("R2 set pin3", 32'(pad_oe), 32'h8000);
    check("R7 pullups", 32'(pad_pu), 32'hA5C3);
  endtask

  task automatic t_nop;
    send(2'b00, 4'd15);
    check("R11 nop latches", 32'(pad_oe), 32'h8000);
    check("R11 nop no rsp", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_test;
    @(negedge clk); pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    send(2'b11, 4'd2);
    check("R5 rsp_valid", 32'(rsp_valid), 32'h1);
    check("R5 pin2", 32'(rsp_level), 32'h1);
    send(2'b11, 4'd0);
    check("R5 pin0", 32'(rsp_level), 32'h0);
    send(2'b11, 4'd12);
    check("R5 pin12", 32'(rsp_level), 32'h1);
    @(negedge clk);
    check("R6 drained", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_backpressure;
    @(negedge clk); rsp_ready = 0;
    send(2'b11, 4'd4);
    check("R6 rsp up", 32'(rsp_valid), 32'h1);
    check("R6 level pin4", 32'(rsp_level), 32'h1);
    check("R6 ready low", 32'(cmd_ready), 32'h0);
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    check("R6 held valid", 32'(rsp_valid), 32'h1);
    check("R6 held level", 32'(rsp_level), 32'h1);
    cmd_valid = 1; cmd_op = 2'b10; cmd_idx = 4'd5;
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    check("R6 blocked clear", 32'(pad_oe), 32'h8000);
    rsp_ready = 1;
    @(negedge clk);
    check("R6 released", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_halt;
    @(negedge clk); pad_in = 16'hFFFF; halt = 1;
    repeat (3) @(negedge clk);
    check("R8 oe floated", 32'(pad_oe), 32'h0);
    check("R8 pu off", 32'(pad_pu), 32'h0);
    send(2'b11, 4'd1);
    check("R8 test valid", 32'(rsp_valid), 32'h1);
    check("R8 test gated", 32'(rsp_level), 32'h0);
    send(2'b10, 4'd2);
    check("R8 still floated", 32'(pad_oe), 32'h0);
    halt = 0;
    @(negedge clk);
    check("R8 latches back", 32'(pad_oe), 32'h8004);
    check("R8 pu back", 32'(pad_pu), 32'hA5C3);
    send(2'b11, 4'd1);
    check("R8 input back", 32'(rsp_level), 32'h1);
  endtask

  task automatic t_narrow;
    @(negedge clk); n_pad_in = 12'hFFF; n_halt = 1;
    repeat (3) @(negedge clk);
    send_n(2'b10, 4'd1);
    check("R9 oe under halt", 32'(n_pad_oe), 32'h002);
    check("R9 pu under halt", 32'(n_pad_pu), 32'h5A3);
    send_n(2'b11, 4'd7);
    check("R9 test under halt", 32'(n_rsp_level), 32'h1);
    send_n(2'b10, 4'd13);
    check("R10 clear oor", 32'(n_pad_oe), 32'h002);
    send_n(2'b01, 4'd15);
    check("R10 set oor", 32'(n_pad_oe), 32'h002);
    send_n(2'b11, 4'd14);
    check("R10 test oor valid", 32'(n_rsp_valid), 32'h1);
    check("R10 test oor level", 32'(n_rsp_level), 32'h0);
    n_halt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_nop();
    t_test();
    t_backpressure();
    t_halt();
    t_narrow();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule